// File: doc/BRIEF.md
# Presettable Synchronous BCD Counter Stage

This block is one decimal digit of a synchronous counter. It holds a 4-bit binary-coded decimal value that advances 0, 1, ... 9, 0 on rising clock edges while both of its count enables are high. A parallel enable gates counting locally. A trickle enable gates both counting and the carry output, so stages can be chained into a multi-digit counter that shares one clock. Every change of state is synchronous. An active-low clear forces zero. An active-low load copies a 4-bit data word. Both override the enables, and clear wins over load.

The carry output is combinational. It is high while the trickle enable is high and the digit is at nine. For cascading, the carry of a lower digit drives the trickle enable of the next digit, and all digits tie their parallel enables to a common count strobe. Codes 10 to 15 can be loaded. From any of them, counting returns to the decimal range within two clocks along a fixed path.

Top module: `bcd_counter_stage`

## Requirements
- R1: The 4-bit count output changes only on a rising clock edge. Input changes between edges do not alter it, and all four bits are updated at the same edge.
- R2: If the clear input is low at a rising edge, the count becomes 0000 at that edge, whatever the values of both enables and the load input.
- R3: If the clear input is high and the load input is low at a rising edge, the count takes the data-input value at that edge, whatever the values of both enables. Values 10 to 15 are accepted.
- R4: If clear and load are high and both enables are high at a rising edge, a count of 0 to 8 advances by one and a count of 9 becomes 0.
- R5: If clear and load are high and either enable is low, the count keeps its value at the edge. This holds for out-of-range values too.
- R6: When counting is enabled, out-of-range counts advance as 10→11→6, 12→13→4 and 14→15→2. Every count of 10 to 15 is therefore back in 0 to 9 within two enabled edges.
- R7: The carry output is high exactly when the trickle enable is high and the count equals 9, encoded as bit 0 and bit 3 set (1001). It follows input changes without waiting for a clock edge.
- R8: Two stages form a two-digit counter when the carry of the low stage drives the trickle enable of the high stage and both parallel enables are high. That counter steps through 00 to 99 and wraps to 00 without skipping or repeating a value.
- R9: When clear and load are both low at the same edge, clear wins and the count becomes 0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all state |
| clr_n | input | 1 | Synchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| cnt_en_p | input | 1 | Parallel count enable, active high |
| cnt_en_t | input | 1 | Trickle count enable, also gates the carry, active high |
| din | input | 4 | Data word copied in by a load |
| q | output | 4 | Current digit value |
| carry_out | output | 1 | Ripple carry for the next stage |

## Verification
The count output is due one rising edge after the inputs that cause it. The carry output depends on the current count and the trickle enable within the same cycle. The bench drives inputs on the falling edge and checks the carry a moment later, against the count computed for the current cycle. It checks the count just after the next rising edge, against a value advanced by the bench's own next-state function. Before that edge it samples the count once more to confirm that changing inputs left it alone. In the cascade test the check after each edge must show the combined two-digit value equal to the number of edges since the clear, modulo 100.

// File: rtl/bcd_counter_pkg.sv
package bcd_counter_pkg;
   localparam int DIGIT_W    = 4;
   localparam int LAST_DIGIT = 9;

   typedef logic [DIGIT_W-1:0] digit_t;

   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_COUNT = 2'd1,
      OP_LOAD  = 2'd2,
      OP_CLEAR = 2'd3
   } stage_op_e;

   function automatic logic is_decimal(digit_t v);
      return v <= digit_t'(LAST_DIGIT);
   endfunction
endpackage

// File: rtl/bcd_op_decode.sv
module bcd_op_decode
   import bcd_counter_pkg::*;
(
   input  logic      clr_n,
   input  logic      load_n,
   input  logic      en_p,
   input  logic      en_t,
   output stage_op_e op
);
   always_comb begin
      if (!clr_n)              op = OP_CLEAR;
      else if (!load_n)        op = OP_LOAD;
      else if (en_p && en_t)   op = OP_COUNT;
      else                     op = OP_HOLD;
   end
endmodule

// File: rtl/bcd_next_state.sv
module bcd_next_state
   import bcd_counter_pkg::*;
#(
   parameter int NEXT_IMPL = 0   // 0: case table, 1: arithmetic
)(
   input  digit_t cur,
   output digit_t nxt
);
   if (NEXT_IMPL == 0) begin : g_table
      always_comb begin
         unique case (cur)
            4'd0:  nxt = 4'd1;
            4'd1:  nxt = 4'd2;
            4'd2:  nxt = 4'd3;
            4'd3:  nxt = 4'd4;
            4'd4:  nxt = 4'd5;
            4'd5:  nxt = 4'd6;
            4'd6:  nxt = 4'd7;
            4'd7:  nxt = 4'd8;
            4'd8:  nxt = 4'd9;
            4'd9:  nxt = 4'd0;
            4'd10: nxt = 4'd11;
            4'd11: nxt = 4'd6;
            4'd12: nxt = 4'd13;
            4'd13: nxt = 4'd4;
            4'd14: nxt = 4'd15;
            default: nxt = 4'd2;
         endcase
      end
   end else if (NEXT_IMPL == 1) begin : g_arith
      localparam logic [DIGIT_W:0] FOLD_BASE = (DIGIT_W+1)'(17);
      logic [DIGIT_W:0] fold;
      always_comb begin
         fold = FOLD_BASE - {1'b0, cur};
         if (cur < digit_t'(LAST_DIGIT))       nxt = cur + digit_t'(1);
         else if (cur == digit_t'(LAST_DIGIT)) nxt = '0;
         else if (!cur[0])                     nxt = cur + digit_t'(1);
         else                                  nxt = fold[DIGIT_W-1:0];
      end
   end else begin : g_bad
      $error("bcd_next_state: NEXT_IMPL must be 0 or 1");
      assign nxt = '0;
   end
endmodule

// File: rtl/bcd_carry_gen.sv
module bcd_carry_gen
   import bcd_counter_pkg::*;
(
   input  digit_t cur,
   input  logic   en_t,
   output logic   carry
);
   always_comb carry = en_t && (cur == digit_t'(LAST_DIGIT));
endmodule

// File: rtl/bcd_counter_stage.sv
module bcd_counter_stage
   import bcd_counter_pkg::*;
#(
   parameter int NEXT_IMPL = 0
)(
   input  logic       clk,
   input  logic       clr_n,
   input  logic       load_n,
   input  logic       cnt_en_p,
   input  logic       cnt_en_t,
   input  logic [3:0] din,
   output logic [3:0] q,
   output logic       carry_out
);
   if (DIGIT_W != 4) begin : g_width_chk
      $error("bcd_counter_stage: digit width must be 4");
   end

   stage_op_e op;
   digit_t    cnt_q;
   digit_t    cnt_inc;
   digit_t    cnt_d;

   bcd_op_decode u_dec (
      .clr_n (clr_n),
      .load_n(load_n),
      .en_p  (cnt_en_p),
      .en_t  (cnt_en_t),
      .op    (op)
   );

   bcd_next_state #(.NEXT_IMPL(NEXT_IMPL)) u_nxt (
      .cur(cnt_q),
      .nxt(cnt_inc)
   );

   always_comb begin
      unique case (op)
         OP_CLEAR: cnt_d = '0;
         OP_LOAD:  cnt_d = din;
         OP_COUNT: cnt_d = cnt_inc;
         default:  cnt_d = cnt_q;
      endcase
   end

   always_ff @(posedge clk) cnt_q <= cnt_d;

   bcd_carry_gen u_carry (
      .cur  (cnt_q),
      .en_t (cnt_en_t),
      .carry(carry_out)
   );

   assign q = cnt_q;
endmodule

// File: rtl/bcd_counter_stage_chk.sv
module bcd_counter_stage_chk (
   input logic       clk,
   input logic       clr_n,
   input logic       load_n,
   input logic       cnt_en_p,
   input logic       cnt_en_t,
   input logic [3:0] din,
   input logic [3:0] q,
   input logic       carry_out
);
   logic armed = 1'b0;
   always_ff @(posedge clk) if (!clr_n) armed <= 1'b1;

   logic run;
   assign run = clr_n && load_n && cnt_en_p && cnt_en_t;

   // R2
   clear_zero_chk: assert property (@(posedge clk) disable iff (!armed)
      !clr_n |=> q == 4'd0);
   // R3
   load_take_chk: assert property (@(posedge clk) disable iff (!armed)
      (clr_n && !load_n) |=> q == $past(din));
   // R4
   count_step_chk: assert property (@(posedge clk) disable iff (!armed)
      (run && q < 4'd9) |=> q == $past(q) + 4'd1);
   // R4
   count_wrap_chk: assert property (@(posedge clk) disable iff (!armed)
      (run && q == 4'd9) |=> q == 4'd0);
   // R5
   hold_chk: assert property (@(posedge clk) disable iff (!armed)
      (clr_n && load_n && !(cnt_en_p && cnt_en_t)) |=> $stable(q));
   // R6
   bad_even_chk: assert property (@(posedge clk) disable iff (!armed)
      (run && q > 4'd9 && !q[0]) |=> q == $past(q) + 4'd1);
   // R6
   bad_odd_chk: assert property (@(posedge clk) disable iff (!armed)
      (run && q > 4'd9 && q[0]) |=> q <= 4'd9);
   // R7
   carry_match_chk: assert property (@(posedge clk) disable iff (!armed)
      carry_out |-> (cnt_en_t && q == 4'd9));
endmodule

bind bcd_counter_stage bcd_counter_stage_chk chk_i (
   .clk      (clk),
   .clr_n    (clr_n),
   .load_n   (load_n),
   .cnt_en_p (cnt_en_p),
   .cnt_en_t (cnt_en_t),
   .din      (din),
   .q        (q),
   .carry_out(carry_out)
);

// File: tb/bcd_counter_stage_tb_top.sv
module bcd_counter_stage_tb_top;
   logic       clk = 1'b0;
   logic       clr_n = 1'b0, load_n = 1'b1, en_p = 1'b0, en_t = 1'b0;
   logic [3:0] din = 4'd0;
   logic [3:0] q;
   logic       carry_out;

   logic       c_clr_n = 1'b0;
   logic [3:0] lo_q, hi_q;
   logic       lo_c, hi_c;

   int n_run = 0, n_fail = 0;
   bit done = 1'b0;
   logic [3:0] exp_q;

   always #5 clk = ~clk;

   bcd_counter_stage dut_i (
      .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en_p(en_p),
      .cnt_en_t(en_t), .din(din), .q(q), .carry_out(carry_out));

   bcd_counter_stage #(.NEXT_IMPL(1)) casc_lo_i (
      .clk(clk), .clr_n(c_clr_n), .load_n(1'b1), .cnt_en_p(1'b1),
      .cnt_en_t(1'b1), .din(4'd0), .q(lo_q), .carry_out(lo_c));

   bcd_counter_stage #(.NEXT_IMPL(1)) casc_hi_i (
      .clk(clk), .clr_n(c_clr_n), .load_n(1'b1), .cnt_en_p(1'b1),
      .cnt_en_t(lo_c), .din(4'd0), .q(hi_q), .carry_out(hi_c));

   function automatic logic [3:0] model_step(logic [3:0] v);
      case (v)
         4'd9:  return 4'd0;
         4'd11: return 4'd6;
         4'd13: return 4'd4;
         4'd15: return 4'd2;
         default: return v + 4'd1;
      endcase
   endfunction

   function automatic logic [3:0] model_next(logic [3:0] v, logic c, logic l,
                                             logic p, logic t, logic [3:0] d);
      if (!c) return 4'd0;
      if (!l) return d;
      if (p && t) return model_step(v);
      return v;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(logic c, logic l, logic p, logic t, logic [3:0] d);
      string req;
      logic [3:0] prev;
      @(negedge clk);
      clr_n = c; load_n = l; en_p = p; en_t = t; din = d;
      #1;
      prev = exp_q;
      // R7: carry is combinational on current count and trickle enable
      check("R7", 32'(carry_out), 32'(t && prev == 4'd9));
      // R1: inputs changed mid-cycle, count must not move yet
      check("R1", 32'(q), 32'(prev));
      if (!c)          req = l ? "R2" : "R9";
      else if (!l)     req = "R3";
      else if (p && t) req = (prev > 4'd9) ? "R6" : "R4";
      else             req = "R5";
      exp_q = model_next(prev, c, l, p, t, d);
      @(posedge clk);
      #1;
      check(req, 32'(q), 32'(exp_q));
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20251));
      exp_q = 4'd0;
      // reset state via clear
      step(1'b0, 1'b1, 1'b0, 1'b0, 4'd5);
      check("R2", 32'(carry_out), 32'd0);
      // full 0..9 wrap (R4), twice around
      for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 1'b1, 1'b1, 4'd0);
      // load with both enables low (R3), then hold (R5)
      step(1'b1, 1'b0, 1'b0, 1'b0, 4'd7);
      step(1'b1, 1'b1, 1'b0, 1'b1, 4'd3);
      step(1'b1, 1'b1, 1'b1, 1'b0, 4'd3);
      // clear with enables low (R2), clear+load together (R9)
      step(1'b0, 1'b1, 1'b0, 1'b0, 4'd8);
      step(1'b1, 1'b0, 1'b1, 1'b1, 4'd9);
      step(1'b1, 1'b1, 1'b1, 0, 4'd0);      // R7 carry low with trickle low
      step(1'b0, 1'b0, 1'b1, 1'b1, 4'd6);
      // every invalid value: load, hold, then recover (R6)
      for (int v = 10; v < 16; v++) begin
         step(1'b1, 1'b0, 1'b0, 1'b0, 4'(v));
         step(1'b1, 1'b1, 1'b0, 1'b1, 4'd0);
         step(1'b1, 1'b1, 1'b1, 1'b1, 4'd0);
         step(1'b1, 1'b1, 1'b1, 1'b1, 4'd0);
         check("R6", 32'(exp_q <= 4'd9), 32'd1);
      end
      // constrained random mix
      for (int i = 0; i < 400; i++) begin
         logic c, l;
         c = ($urandom % 12) != 0;
         l = ($urandom % 6) != 0;
         step(c, l, ($urandom % 4) != 0, ($urandom % 4) != 0, 4'($urandom));
      end
      // two-stage cascade (R8)
      @(negedge clk);
      c_clr_n = 1'b0;
      @(negedge clk);
      c_clr_n = 1'b1;
      check("R8", 32'(hi_q * 10 + lo_q), 32'd0);
      for (int i = 1; i <= 130; i++) begin
         @(posedge clk);
         #1;
         check("R8", 32'(hi_q * 10 + lo_q), 32'(i % 100));
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule